// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block is a multi-cycle execution unit for bit shifts and rotates on 8, 16 or 32 bit operands. A single-cycle start pulse supplies the operand, the operand size, the operation, a bit count and the incoming condition flags. The unit then moves the operand one bit position per clock until the count is used up. It finishes with a one-cycle done pulse that carries the result and the updated flags.

Seven operations are supported: logical left shift, logical right shift, arithmetic right shift, plain left and right rotation, and left and right rotation through the carry flag. Each operation updates the flags in its own way. Shifts rebuild the sign, zero and parity flags from the result. Rotates leave those three flags alone. Overflow follows a sign-change rule and is written only for single-bit counts.

Top module: `shift_rotate_unit`

## Requirements
- R1: A start seen while `busy_o` is low is accepted. With N = count_i modulo 32, `busy_o` is high in the N+1 cycles after the accepting edge, and `done_o` is high for exactly one cycle, N+1 clock edges after the accepting edge.
- R2: A start while `busy_o` is high is ignored. The running operation completes with its own result and no extra done pulse appears.
- R3: Left shift (op 0) moves every bit up one place per step, fills bit 0 with zero, and puts the bit leaving the top of the selected size into CF.
- R4: Logical right shift (op 1) fills the top bit with zero, for example 0xFFFF by 1 at 16 bits gives 0x7FFF. Arithmetic right shift (op 2) copies the top bit into itself, so -15 by 1 at 16 bits gives 0xFFF8 (-8). Both put the bit leaving bit 0 into CF.
- R5: Rotate left (op 3) sends the old top bit into both bit 0 and CF. Rotate right (op 4) sends the old bit 0 into both the top bit and CF.
- R6: Rotate left through carry (op 5) and rotate right through carry (op 6) treat CF as one more bit of an (n+1)-bit ring. A count of n+1 returns the original operand and the original CF.
- R7: When the effective count is 1, OF = (top bit of result) XOR (top bit of operand). For any other count, OF keeps its input value.
- R8: For the rotates, SF, ZF and PF leave the unit unchanged. For the shifts with a non-zero count, SF is the top bit of the result, ZF is set when the result is zero, and PF is set when the low byte of the result has an even number of ones.
- R9: size_i 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected size have no effect, and result bits above it are zero.
- R10: The count is taken modulo 32, so 33 acts as 1 and 32 acts as 0. A zero effective count, or op 7, returns the size-masked operand with all five flags unchanged.
- R11: Flag vectors use the bit positions [0] CF, [1] PF, [2] ZF, [3] SF, [4] OF on both `flags_i` and `flags_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| operand_i | input | 32 | Value to shift or rotate |
| size_i | input | 2 | Operand size select |
| op_i | input | 3 | Operation select (0..6, 7 = no move) |
| count_i | input | 8 | Bit count, used modulo 32 |
| flags_i | input | 5 | Incoming flags {OF,SF,ZF,PF,CF} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result, held until the next completion |
| flags_o | output | 5 | Updated flags {OF,SF,ZF,PF,CF} |

## Verification
The assertions take for granted that operation, size and count are stable only at the accepting edge. They do not need these inputs to stay stable afterwards, and the latched copies are what they compare against. They also assume that a start arriving during a run never reloads those copies. The stimulus keeps the inputs stable only for the one cycle of each start. It deliberately pulses start with unrelated values in the middle of a long run, and it fills the bits above the selected size with random data. This exercises the ignore and masking rules without ever leaving the input space the properties describe.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_SHL = 3'd0, OP_SHR = 3'd1, OP_SAR = 3'd2, OP_ROL = 3'd3,
    OP_ROR = 3'd4, OP_RCL = 3'd5, OP_RCR = 3'd6, OP_NOP = 3'd7
  } sru_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_W2 = 2'd3
  } sru_size_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } sru_flags_t;

  function automatic logic [DATA_W-1:0] size_mask(sru_size_e sz);
    case (sz)
      SZ_B:    return DATA_W'(32'h0000_00FF);
      SZ_H:    return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] top_idx(sru_size_e sz);
    case (sz)
      SZ_B:    return IDX_W'(7);
      SZ_H:    return IDX_W'(15);
      default: return IDX_W'(DATA_W - 1);
    endcase
  endfunction

  function automatic logic is_rotate(sru_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

  function automatic logic even_ones(logic [7:0] b);
    return ~(^b);
  endfunction

  // One bit position of the selected operation: returns {carry_out, data}
  function automatic logic [DATA_W:0] shift_one(sru_op_e op, sru_size_e sz,
                                                logic [DATA_W-1:0] d, logic cin);
    logic [DATA_W-1:0] m, topb, r;
    logic hi, lo, co;
    m    = size_mask(sz);
    topb = DATA_W'(1) << top_idx(sz);
    hi   = d[top_idx(sz)];
    lo   = d[0];
    r    = d;
    co   = cin;
    case (op)
      OP_SHL: begin r = d << 1;                          co = hi; end
      OP_SHR: begin r = d >> 1;                          co = lo; end
      OP_SAR: begin r = (d >> 1) | (hi  ? topb : '0);    co = lo; end
      OP_ROL: begin r = (d << 1) | DATA_W'(hi);          co = hi; end
      OP_ROR: begin r = (d >> 1) | (lo  ? topb : '0);    co = lo; end
      OP_RCL: begin r = (d << 1) | DATA_W'(cin);         co = hi; end
      OP_RCR: begin r = (d >> 1) | (cin ? topb : '0);    co = lo; end
      default: ;
    endcase
    return {co, r & m};
  endfunction
endpackage

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
(
  input  sru_op_e            op_i,
  input  sru_size_e          size_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               carry_o
);
  logic [DATA_W:0] packed_w;

  always_comb begin
    packed_w = shift_one(op_i, size_i, data_i, carry_i);
    data_o   = packed_w[DATA_W-1:0];
    carry_o  = packed_w[DATA_W];
  end
endmodule

// File: rtl/sru_flags.sv
module sru_flags
  import sru_pkg::*;
(
  input  sru_op_e            op_i,
  input  sru_size_e          size_i,
  input  logic [DATA_W-1:0]  result_i,
  input  logic               carry_i,
  input  logic               src_top_i,
  input  logic               single_i,
  input  logic               moved_i,
  input  sru_flags_t         flags_i,
  output sru_flags_t         flags_o
);
  logic res_top_w;

  always_comb begin
    res_top_w  = result_i[top_idx(size_i)];
    flags_o    = flags_i;
    flags_o.cf = carry_i;
    if (single_i) flags_o.of = res_top_w ^ src_top_i;
    if (moved_i && !is_rotate(op_i)) begin
      flags_o.sf = res_top_w;
      flags_o.zf = (result_i == '0);
      flags_o.pf = even_ones(result_i[7:0]);
    end
  end
endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned MOD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             nop_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic             finish_o
);
  logic             busy_q;
  logic [MOD_W-1:0] left_q;

  assign busy_o   = busy_q;
  assign load_o   = start_i && !busy_q;
  assign step_o   = busy_q && (left_q != '0);
  assign finish_o = busy_q && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      left_q <= nop_i ? '0 : count_i[MOD_W-1:0];
    end else if (step_o) begin
      left_q <= left_q - 1'b1;
    end else if (finish_o) begin
      busy_q <= 1'b0;
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R1
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !busy_o);
  // R2
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && start_i) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   operand_i,
  input  logic [1:0]          size_i,
  input  logic [2:0]          op_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic [4:0]          flags_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   result_o,
  output logic [4:0]          flags_o
);
  localparam int unsigned MOD_W = 5;

  sru_op_e           op_in_w;
  sru_size_e         sz_in_w;
  sru_flags_t        fl_in_w;
  logic              load_w, step_w, finish_w, nop_w;
  logic [MOD_W-1:0]  eff_cnt_w;

  sru_op_e           op_q;
  sru_size_e         sz_q;
  sru_flags_t        flags_q;
  logic [DATA_W-1:0] data_q;
  logic              carry_q, src_top_q, single_q, moved_q;

  logic [DATA_W-1:0] step_data_w;
  logic              step_carry_w;
  sru_flags_t        flags_calc_w;

  assign op_in_w   = sru_op_e'(op_i);
  assign sz_in_w   = sru_size_e'(size_i);
  assign fl_in_w   = sru_flags_t'(flags_i);
  assign nop_w     = (op_in_w == OP_NOP);
  assign eff_cnt_w = count_i[MOD_W-1:0];

  sru_ctrl #(.CNT_W(CNT_W), .MOD_W(MOD_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .count_i  (count_i),
    .nop_i    (nop_w),
    .busy_o   (busy_o),
    .load_o   (load_w),
    .step_o   (step_w),
    .finish_o (finish_w)
  );

  sru_step step_i (
    .op_i    (op_q),
    .size_i  (sz_q),
    .data_i  (data_q),
    .carry_i (carry_q),
    .data_o  (step_data_w),
    .carry_o (step_carry_w)
  );

  sru_flags flags_i0 (
    .op_i      (op_q),
    .size_i    (sz_q),
    .result_i  (data_q),
    .carry_i   (carry_q),
    .src_top_i (src_top_q),
    .single_i  (single_q),
    .moved_i   (moved_q),
    .flags_i   (flags_q),
    .flags_o   (flags_calc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_NOP;
      sz_q      <= SZ_W;
      flags_q   <= '0;
      data_q    <= '0;
      carry_q   <= 1'b0;
      src_top_q <= 1'b0;
      single_q  <= 1'b0;
      moved_q   <= 1'b0;
    end else if (load_w) begin
      op_q      <= op_in_w;
      sz_q      <= sz_in_w;
      flags_q   <= fl_in_w;
      data_q    <= operand_i & size_mask(sz_in_w);
      carry_q   <= fl_in_w.cf;
      src_top_q <= operand_i[top_idx(sz_in_w)];
      single_q  <= !nop_w && (eff_cnt_w == MOD_W'(1));
      moved_q   <= !nop_w && (eff_cnt_w != '0);
    end else if (step_w) begin
      data_q    <= step_data_w;
      carry_q   <= step_carry_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      done_o <= finish_w;
      if (finish_w) begin
        result_o <= data_q;
        flags_o  <= flags_calc_w;
      end
    end
  end

  // R3
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && op_q == OP_SHL) |-> (step_data_w[0] == 1'b0));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((result_o & ~size_mask(sz_q)) == '0));
  // R8
  rot_keep_szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && is_rotate(op_q)) |->
      (flags_o[3:1] == {flags_q.sf, flags_q.zf, flags_q.pf}));
  // R7
  of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !single_q) |-> (flags_o[4] == flags_q.of));
  // R10
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !moved_q) |-> (flags_o == flags_q));
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  op_i = '0;
  logic [7:0]  count_i = '0;
  logic [4:0]  flags_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  fl;
    int          due;
    int          req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  shift_rotate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .size_i(size_i), .op_i(op_i), .count_i(count_i), .flags_i(flags_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(bit ok, int req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ring_rot(logic [63:0] x, int len, int k, bit left);
    logic [63:0] m;
    m = (64'd1 << len) - 1;
    x = x & m;
    if (k == 0) return x;
    if (left) return ((x << k) | (x >> (len - k))) & m;
    return ((x >> k) | (x << (len - k))) & m;
  endfunction

  // Closed-form expectation, independent of the stepwise hardware
  function automatic void model(input int op, input int sz, input logic [31:0] val,
                                input int cnt, input logic [4:0] fin,
                                output logic [31:0] r, output logic [4:0] fo);
    int w, n;
    logic [63:0] m, v, t;
    logic signed [63:0] s;
    logic c;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    v = {32'd0, val} & m;
    n = cnt % 32;
    fo = fin;
    c = fin[0];
    if (op == 7 || n == 0) begin
      r = v[31:0];
      return;
    end
    case (op)
      0: begin t = (v << n) & m; c = (n <= w) ? v[w-n] : 1'b0; end
      1: begin t = v >> n;       c = (n <= w) ? v[n-1] : 1'b0; end
      2: begin
        s = v[w-1] ? signed'(v | ~m) : signed'(v);
        t = 64'(s >>> n) & m;
        c = (n <= w) ? v[n-1] : v[w-1];
      end
      3: begin t = ring_rot(v, w, n % w, 1'b1); c = t[0]; end
      4: begin t = ring_rot(v, w, n % w, 1'b0); c = t[w-1]; end
      5, 6: begin
        t = ring_rot(v | (64'(fin[0]) << w), w + 1, n % (w + 1), op == 5);
        c = t[w];
        t = t & m;
      end
      default: t = v;
    endcase
    r = t[31:0];
    fo[0] = c;
    if (n == 1) fo[4] = t[w-1] ^ v[w-1];
    if (op <= 2) begin
      fo[3] = t[w-1];
      fo[2] = (t == 0);
      fo[1] = ~(^t[7:0]);
    end
  endfunction

  // Driver: waits for idle, pulses start, pushes the expectation
  task automatic issue(int op, int sz, logic [31:0] val, int cnt, logic [4:0] fl, int req);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    model(op, sz, val, cnt, fl, e.res, e.fl);
    e.req = req;
    operand_i = val; size_i = 2'(sz); op_i = 3'(op); count_i = 8'(cnt); flags_i = fl;
    start_i = 1'b1;
    @(posedge clk);
    #1;
    e.due = cyc + ((op == 7) ? 0 : (cnt % 32)) + 1;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: compares every done pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        // R2: a done with nothing pending means an ignored start was taken
        check(1'b0, 2, "unexpected done", result_o, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result_o == e.res, e.req, "result", result_o, e.res);
        check(flags_o == e.fl, e.req, "flags", 32'(flags_o), 32'(e.fl));
        // R1 latency
        check(cyc == e.due, 1, "done cycle", 32'(cyc), 32'(e.due));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(done_o == 1'b0, 1, "reset done", 32'(done_o), 32'h0);
    check(busy_o == 1'b0, 1, "reset busy", 32'(busy_o), 32'h0);
    check(result_o == '0, 1, "reset result", result_o, 32'h0);
    check(flags_o == '0, 11, "reset flags", 32'(flags_o), 32'h0);
    rst_n = 1'b1;

    // R4 arithmetic right: -15 >> 1 at 16 bits -> 0xFFF8
    issue(2, 1, 32'h0000_FFF1, 1, 5'b00000, 4);
    // R4 logical right: 0xFFFF >> 1 -> 0x7FFF, OF set (R7)
    issue(1, 1, 32'h0000_FFFF, 1, 5'b00000, 4);
    // R3 left shift at 8 bits, top bit into CF; R7 sign change
    issue(0, 0, 32'h0000_0081, 1, 5'b00000, 3);
    // R3 multi-bit left shift, CF from last bit out
    issue(0, 1, 32'h0000_1234, 4, 5'b10000, 3);
    // R5 rotate left and right
    issue(3, 0, 32'h0000_0081, 1, 5'b01110, 5);
    issue(4, 1, 32'h0000_0001, 3, 5'b00000, 5);
    // R6 through-carry ring of n+1 restores operand and CF
    issue(5, 0, 32'h0000_00A5, 9, 5'b00001, 6);
    issue(6, 1, 32'h0000_8E21, 17, 5'b01010, 6);
    issue(5, 2, 32'h8000_0001, 3, 5'b00001, 6);
    // R8 rotate keeps SF/ZF/PF
    issue(3, 2, 32'hF000_000F, 5, 5'b01110, 8);
    // R9 upper bits ignored and returned as zero
    issue(1, 0, 32'hDEAD_BE80, 2, 5'b00000, 9);
    issue(0, 1, 32'hFFFF_8001, 1, 5'b00000, 9);
    // R10 zero count, count 32, count 33, op 7
    issue(0, 0, 32'hABCD_EF12, 0, 5'b11111, 10);
    issue(2, 1, 32'h1234_8000, 32, 5'b10101, 10);
    issue(0, 2, 32'h4000_0000, 33, 5'b00000, 10);
    issue(7, 2, 32'h5555_AAAA, 5, 5'b01011, 10);
    // R7 OF held for count other than one
    issue(0, 0, 32'h0000_0040, 2, 5'b10000, 7);
    // R3 shift out past the width
    issue(0, 0, 32'h0000_00FF, 12, 5'b00001, 3);
    issue(2, 0, 32'h0000_0080, 20, 5'b00000, 4);

    // R2 start during a run is ignored
    issue(1, 2, 32'hF0F0_0F0F, 20, 5'b00000, 2);
    repeat (3) @(negedge clk);
    operand_i = 32'h1111_1111; op_i = 3'd0; count_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, 2, "busy after ignored start", 32'(busy_o), 32'h1);

    // R11 random mix over all operations, sizes and flag patterns
    for (int i = 0; i < 200; i++) begin
      issue(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), $urandom,
            int'($urandom_range(0, 40)), 5'($urandom), 11);
    end

    @(negedge clk);
    while (busy_o || sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    // R2 nothing left pending
    check(sb.size() == 0, 2, "scoreboard empty", 32'(sb.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule